// File: doc/BRIEF.md
# Write-back data cache with victim queue

A small fully associative data cache that serves byte loads and byte stores from a processor. Stores only touch the cached copy and mark the line dirty; main memory sees a line again only when that line is evicted, and then always as a whole block. Misses, whether from a load or a store, bring the full block in and allocate it before the access completes, so a store miss becomes a fill followed by a store hit.

Dirty victims are not written to memory inline. They go to the tail of a short queue, and the queue drains from its head over a separate block-write channel while the cache carries on. A later miss to an address that still sits in the queue takes its data from the queue instead of memory, so a stale block is never read. A flush request pushes every dirty line through the queue, invalidates the whole array, and signals completion once the queue is empty. Hit and miss counters report how the cache is doing.

Top module: `wb_cache`

## Requirements
- R1: A request that hits completes with `cpu_ready` high in the same cycle the request is presented in the idle state; a load returns the most recently stored value of that byte address.
- R2: A miss reads the whole block with `mem_rd_addr` equal to the byte address shifted right by log2(block bytes); the line is then allocated valid and clean with the new tag and block, and the request completes as a hit on the next idle cycle.
- R3: A store sets the line dirty and causes no memory write at store time.
- R4: Evicting a clean line produces no memory write.
- R5: Evicting a dirty line enqueues the entire block with its block address; the queue drains oldest first, and each head entry keeps `mem_wr_req`, address and data steady until `mem_wr_ack`.
- R6: `mem_rd_req` stays high with a steady address until `mem_rd_ack`.
- R7: Victims are chosen among invalid lines first (lowest index), otherwise the least recently used line.
- R8: With the queue full and a dirty victim, the miss stalls with no block read until an entry drains.
- R9: A miss whose block address matches a queued entry takes the newest matching entry's data and issues no memory read.
- R10: A flush writes back all dirty lines through the queue, leaves every line invalid, and pulses `flush_done` once the queue is empty.
- R11: `hit_count` increments once per first-try hit and `miss_count` once per miss; the completion after a fill counts as neither.
- R12: After reset every line is invalid, the queue is empty and both counters read zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cpu_valid | input | 1 | Request present; held with its fields until `cpu_ready` |
| cpu_we | input | 1 | 1 = store, 0 = load |
| cpu_addr | input | AW | Byte address |
| cpu_wdata | input | 8 | Store byte |
| cpu_ready | output | 1 | Request completes this cycle |
| cpu_rdata | output | 8 | Load byte, valid with `cpu_ready` |
| mem_rd_req | output | 1 | Block read request |
| mem_rd_addr | output | AW-log2(BLKB) | Block address to read |
| mem_rd_ack | input | 1 | Read data valid, read done |
| mem_rd_data | input | 8*BLKB | Block read data, byte 0 in the low bits |
| mem_wr_req | output | 1 | Queue head waiting to be written |
| mem_wr_addr | output | AW-log2(BLKB) | Block address of the queue head |
| mem_wr_data | output | 8*BLKB | Whole block of the queue head |
| mem_wr_ack | input | 1 | Head written; entry is removed |
| flush | input | 1 | Request to write back and invalidate all lines |
| flush_done | output | 1 | One-cycle pulse at flush completion |
| hit_count | output | CW | Hits counted |
| miss_count | output | CW | Misses counted |

## Verification
The bench sweeps every byte address with stores and loads in several orders against a byte-level reference and a recency-list model of the counters; a wrong LRU choice or a replay counted as a hit shows up as counter drift, and a lost dirty byte as a bad load. It holds off write acknowledgements to fill the queue, then re-reads a just-evicted block: a design without forwarding either reads stale memory or issues a block read the bench counts. A dirty eviction with a full queue must stall with no read; a design that overwrote the tail would lose a line visible after the final flush. Clean evictions and store hits must leave the write channel silent, and the flush must leave memory equal to the reference and the next access a miss.

// File: rtl/wb_cache.sv
module wb_cache #(
  parameter int AW    = 6,
  parameter int LINES = 4,
  parameter int BLKB  = 4,
  parameter int QD    = 2,
  parameter int CW    = 16
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     cpu_valid,
  input  logic                     cpu_we,
  input  logic [AW-1:0]            cpu_addr,
  input  logic [7:0]               cpu_wdata,
  output logic                     cpu_ready,
  output logic [7:0]               cpu_rdata,
  output logic                     mem_rd_req,
  output logic [AW-$clog2(BLKB)-1:0] mem_rd_addr,
  input  logic                     mem_rd_ack,
  input  logic [8*BLKB-1:0]        mem_rd_data,
  output logic                     mem_wr_req,
  output logic [AW-$clog2(BLKB)-1:0] mem_wr_addr,
  output logic [8*BLKB-1:0]        mem_wr_data,
  input  logic                     mem_wr_ack,
  input  logic                     flush,
  output logic                     flush_done,
  output logic [CW-1:0]            hit_count,
  output logic [CW-1:0]            miss_count
);
  localparam int OW = $clog2(BLKB);
  localparam int TW = AW - OW;
  localparam int BW = 8 * BLKB;
  localparam int LW = $clog2(LINES);
  localparam int QW = $clog2(QD);

  typedef enum logic [2:0] {S_IDLE, S_EVICT, S_FILL, S_FLUSH, S_FDONE} st_t;
  st_t st;

  logic [LINES-1:0] vld, dty;
  logic [TW-1:0]    tag [LINES];
  logic [BW-1:0]    dat [LINES];
  logic [LW-1:0]    age [LINES];
  logic [TW-1:0]    qa [QD];
  logic [BW-1:0]    qd [QD];
  logic [QW-1:0]    qh, qt;
  logic [QW:0]      qn;
  logic [LW-1:0]    vic, fidx;
  logic             replay;

  logic [TW-1:0]    req_tag;
  logic [OW-1:0]    off;
  logic             hit, fwd_hit, anyinv;
  logic [LW-1:0]    hway, inv, old, vsel, pidx;
  logic [BW-1:0]    fwd_data;
  logic [LINES-1:0] oldv;

  assign req_tag = cpu_addr[AW-1:OW];
  assign off     = cpu_addr[OW-1:0];

  always_comb begin
    hit = 1'b0; hway = '0;
    inv = '0; anyinv = 1'b0; old = '0; oldv = '0;
    for (int i = 0; i < LINES; i++) begin
      if (vld[i] && tag[i] == req_tag) begin hit = 1'b1; hway = LW'(i); end
      oldv[i] = (age[i] == LW'(LINES-1));
      if (oldv[i]) old = LW'(i);
    end
    for (int i = LINES-1; i >= 0; i--)
      if (!vld[i]) begin inv = LW'(i); anyinv = 1'b1; end
    vsel = anyinv ? inv : old;
  end

  always_comb begin
    fwd_hit = 1'b0; fwd_data = '0;
    for (int k = 0; k < QD; k++) begin
      logic [QW-1:0] idx;
      idx = qh + QW'(k);
      if ((QW+1)'(k) < qn && qa[idx] == req_tag) begin
        fwd_hit = 1'b1; fwd_data = qd[idx];
      end
    end
  end

  wire flush_go = flush && !replay;
  wire room     = (qn != (QW+1)'(QD));
  assign pidx   = (st == S_FLUSH) ? fidx : vic;
  wire pdirty   = vld[pidx] && dty[pidx];
  wire push     = (st == S_EVICT || st == S_FLUSH) && pdirty && room;
  wire pop      = mem_wr_req && mem_wr_ack;

  assign cpu_ready   = (st == S_IDLE) && cpu_valid && hit && !flush_go;
  assign cpu_rdata   = dat[hway][{off, 3'b000} +: 8];
  assign mem_rd_req  = (st == S_FILL) && !fwd_hit;
  assign mem_rd_addr = req_tag;
  assign mem_wr_req  = (qn != '0);
  assign mem_wr_addr = qa[qh];
  assign mem_wr_data = qd[qh];
  assign flush_done  = (st == S_FDONE) && (qn == '0);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st <= S_IDLE; vld <= '0; dty <= '0;
      qh <= '0; qt <= '0; qn <= '0;
      vic <= '0; fidx <= '0; replay <= 1'b0;
      hit_count <= '0; miss_count <= '0;
      for (int i = 0; i < LINES; i++) begin
        age[i] <= LW'(i); tag[i] <= '0; dat[i] <= '0;
      end
      for (int k = 0; k < QD; k++) begin qa[k] <= '0; qd[k] <= '0; end
    end else begin
      if (push) begin
        qa[qt] <= tag[pidx]; qd[qt] <= dat[pidx]; qt <= qt + 1'b1;
      end
      if (pop) qh <= qh + 1'b1;
      qn <= qn + (QW+1)'(push) - (QW+1)'(pop);

      case (st)
        S_IDLE: begin
          if (flush_go) begin
            st <= S_FLUSH; fidx <= '0;
          end else if (cpu_valid) begin
            if (hit) begin
              replay <= 1'b0;
              if (!replay) hit_count <= hit_count + 1'b1;
              for (int i = 0; i < LINES; i++)
                if (LW'(i) == hway) age[i] <= '0;
                else if (age[i] < age[hway]) age[i] <= age[i] + 1'b1;
              if (cpu_we) begin
                dat[hway][{off, 3'b000} +: 8] <= cpu_wdata;
                dty[hway] <= 1'b1;
              end
            end else begin
              miss_count <= miss_count + 1'b1;
              vic <= vsel;
              st  <= S_EVICT;
            end
          end
        end
        S_EVICT: begin
          if (!pdirty || room) begin
            vld[vic] <= 1'b0; dty[vic] <= 1'b0; st <= S_FILL;
          end
        end
        S_FILL: begin
          if (fwd_hit || mem_rd_ack) begin
            vld[vic] <= 1'b1; dty[vic] <= 1'b0; tag[vic] <= req_tag;
            dat[vic] <= fwd_hit ? fwd_data : mem_rd_data;
            replay <= 1'b1;
            st <= S_IDLE;
          end
        end
        S_FLUSH: begin
          if (!pdirty || room) begin
            vld[fidx] <= 1'b0; dty[fidx] <= 1'b0;
            if (fidx == LW'(LINES-1)) st <= S_FDONE;
            else fidx <= fidx + 1'b1;
          end
        end
        S_FDONE: if (qn == '0) st <= S_IDLE;
        default: st <= S_IDLE;
      endcase
    end
  end

  // R5: queue head held until acknowledged
  a_r5_head_hold: assert property (@(posedge clk) disable iff (!rst_n)
    mem_wr_req && !mem_wr_ack |=> mem_wr_req && $stable(mem_wr_addr) && $stable(mem_wr_data));
  a_r5_no_overflow: assert property (@(posedge clk) disable iff (!rst_n)
    qn <= (QW+1)'(QD));
  // R6: read request held until acknowledged
  a_r6_rd_hold: assert property (@(posedge clk) disable iff (!rst_n)
    mem_rd_req && !mem_rd_ack |=> mem_rd_req && $stable(mem_rd_addr));
  // R2: a completed fill leaves the line valid and clean
  a_r2_fill_clean: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_FILL) && (fwd_hit || mem_rd_ack) |=> vld[vic] && !dty[vic]);
  // R7: exactly one line is oldest
  a_r7_one_oldest: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot(oldv));
  // R10: completion leaves the array empty
  a_r10_done_empty: assert property (@(posedge clk) disable iff (!rst_n)
    flush_done |-> vld == '0);
  // R8: a full queue with a dirty victim stalls reads
  a_r8_stall: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_EVICT) && vld[vic] && dty[vic] && !room |=> !mem_rd_req);
endmodule

// File: tb/sim_wb_cache.sv
`timescale 1ns/1ps
module sim_wb_cache;
  localparam int AW = 6, LINES = 4, BLKB = 4, QD = 2, CW = 16;
  localparam int TW = AW - $clog2(BLKB);
  localparam int NB = 1 << AW;

  logic clk = 0, rst_n = 0;
  logic cpu_valid = 0, cpu_we = 0, flush = 0;
  logic [AW-1:0] cpu_addr = '0;
  logic [7:0] cpu_wdata = '0, cpu_rdata;
  logic cpu_ready, mem_rd_req, mem_wr_req, flush_done;
  logic mem_rd_ack = 0, mem_wr_ack = 0;
  logic [TW-1:0] mem_rd_addr, mem_wr_addr;
  logic [8*BLKB-1:0] mem_rd_data = '0, mem_wr_data;
  logic [CW-1:0] hit_count, miss_count;

  wb_cache #(.AW(AW), .LINES(LINES), .BLKB(BLKB), .QD(QD), .CW(CW)) u0 (.*);

  always #2 clk = ~clk;

  int total = 0, bad = 0, cyc = 0;
  int rd_cnt = 0, wr_cnt = 0;
  logic wr_hold = 0;
  logic [7:0] refm [NB];
  logic [7:0] bm [NB];
  int exp_hit = 0, exp_miss = 0;
  int lru_tag [LINES];
  int lru_len = 0;

  task automatic chk(input string r, input logic ok, input int act, input int exp);
    total++;
    if (!ok) begin bad++; $display("FAIL %s actual=%0h expected=%0h", r, act, exp); end
  endtask

  task automatic model(input int t);
    int pos = -1;
    for (int i = 0; i < lru_len; i++) if (lru_tag[i] == t) pos = i;
    if (pos >= 0) begin
      exp_hit++;
      for (int i = pos; i > 0; i--) lru_tag[i] = lru_tag[i-1];
    end else begin
      exp_miss++;
      if (lru_len < LINES) lru_len++;
      for (int i = lru_len-1; i > 0; i--) lru_tag[i] = lru_tag[i-1];
    end
    lru_tag[0] = t;
  endtask

  initial forever begin
    @(negedge clk);
    if (mem_rd_req && !mem_rd_ack) begin
      for (int j = 0; j < BLKB; j++) mem_rd_data[j*8 +: 8] = bm[mem_rd_addr*BLKB + j];
      mem_rd_ack = 1; rd_cnt++;
    end else mem_rd_ack = 0;
  end

  initial forever begin
    @(negedge clk);
    if (mem_wr_req && !mem_wr_ack && !wr_hold) begin
      for (int j = 0; j < BLKB; j++) bm[mem_wr_addr*BLKB + j] = mem_wr_data[j*8 +: 8];
      mem_wr_ack = 1; wr_cnt++;
    end else mem_wr_ack = 0;
  end

  initial begin
    forever begin
      @(posedge clk); cyc++;
      if (cyc > 150000) begin
        total++; bad++;
        $display("FAIL watchdog actual=%0d expected=%0d", cyc, 150000);
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
      end
    end
  end

  task automatic acc(input logic we, input int a, input logic [7:0] d, input string r);
    @(negedge clk);
    cpu_valid = 1; cpu_we = we; cpu_addr = AW'(a); cpu_wdata = d;
    forever begin #1; if (cpu_ready) break; @(negedge clk); end
    if (!we) chk(r, cpu_rdata == refm[a], cpu_rdata, refm[a]);
    @(posedge clk); #1;
    cpu_valid = 0;
    if (we) refm[a] = d;
    model(a / BLKB);
  endtask

  task automatic do_flush();
    @(negedge clk); flush = 1;
    forever begin #1; if (flush_done) break; @(negedge clk); end
    @(posedge clk); #1; flush = 0;
    lru_len = 0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    int w0, r0;
    for (int i = 0; i < NB; i++) begin bm[i] = 8'(i * 7 + 3); refm[i] = bm[i]; end
    repeat (3) @(negedge clk);
    // R12: reset state
    chk("R12", hit_count == 0 && miss_count == 0, hit_count, 0);
    chk("R12", !cpu_ready && !mem_rd_req && !mem_wr_req && !flush_done, mem_wr_req, 0);
    rst_n = 1;

    // R1 R2 R7 R11: sweeps
    for (int a = 0; a < NB; a++) acc(1, a, 8'(a ^ 8'h5A), "R1");
    for (int a = NB-1; a >= 0; a--) acc(0, a, 0, "R1");
    for (int i = 0; i < NB; i++) acc(0, (i * 20) % NB, 0, "R2");
    for (int i = 0; i < NB; i++) acc((i % 3) == 0, (i * 37 + 5) % NB, 8'(i + 8'h90), "R7");
    for (int i = 0; i < NB; i++) acc(0, (i * 13) % NB, 0, "R9");
    chk("R11", hit_count == CW'(exp_hit), hit_count, exp_hit);
    chk("R11", miss_count == CW'(exp_miss), miss_count, exp_miss);

    // R4: clean evictions
    do_flush();
    for (int b = 0; b < 4; b++) acc(0, b * BLKB, 0, "R4");
    w0 = wr_cnt;
    for (int b = 4; b < 8; b++) acc(0, b * BLKB, 0, "R4");
    idle(6);
    chk("R4", wr_cnt == w0 && !mem_wr_req, wr_cnt, w0);

    // R3: store hit stays in the cache
    acc(1, 17, ~refm[17], "R3");
    idle(10);
    chk("R3", wr_cnt == w0, wr_cnt, w0);
    chk("R3", bm[17] != refm[17], bm[17], refm[17]);

    // R5: dirty line (block 4) evicted as a whole
    for (int b = 8; b < 12; b++) acc(0, b * BLKB, 0, "R5");
    idle(6);
    chk("R5", wr_cnt == w0 + 1, wr_cnt, w0 + 1);
    for (int j = 16; j < 20; j++) chk("R5", bm[j] == refm[j], bm[j], refm[j]);

    // R9 and R8: held writes, forwarding, full queue stall
    do_flush();
    wr_hold = 1;
    for (int b = 0; b < 4; b++) acc(1, b * BLKB + 2, 8'(8'hC0 + b), "R8");
    acc(0, 4 * BLKB, 0, "R9");
    r0 = rd_cnt;
    acc(0, 1, 0, "R9");
    chk("R9", rd_cnt == r0, rd_cnt, r0);
    acc(0, 2, 0, "R9");
    chk("R9", bm[2] != refm[2], bm[2], refm[2]);
    @(negedge clk);
    cpu_valid = 1; cpu_we = 0; cpu_addr = AW'(5 * BLKB);
    begin
      int seen = 0;
      repeat (20) begin #1; if (cpu_ready || mem_rd_req) seen++; @(negedge clk); end
      chk("R8", seen == 0, seen, 0);
      chk("R8", mem_wr_req && rd_cnt == r0, rd_cnt, r0);
    end
    wr_hold = 0;
    forever begin #1; if (cpu_ready) break; @(negedge clk); end
    chk("R8", cpu_rdata == refm[5 * BLKB], cpu_rdata, refm[5 * BLKB]);
    @(posedge clk); #1; cpu_valid = 0;
    model(5);
    idle(10);
    for (int j = 0; j < 3 * BLKB; j++) chk("R5", bm[j] == refm[j], bm[j], refm[j]);

    // R10: flush writes everything back and invalidates
    acc(1, 40, 8'hEE, "R10");
    do_flush();
    for (int j = 0; j < NB; j++) chk("R10", bm[j] == refm[j], bm[j], refm[j]);
    w0 = miss_count;
    acc(0, 40, 0, "R10");
    chk("R10", miss_count == CW'(w0 + 1), miss_count, w0 + 1);
    chk("R11", hit_count == CW'(exp_hit), hit_count, exp_hit);
    chk("R11", miss_count == CW'(exp_miss), miss_count, exp_miss);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule